// File: doc/BRIEF.md
# Fetch Target Queue with Prediction Override

This block sits between a two-level branch predictor and instruction fetch. The fast level of the predictor writes one prediction per cycle into a fresh entry. It may do so only while it holds a free-slot credit from the queue. Entries leave toward fetch in order, one per cycle, and only while fetch has granted credits. Each entry carries a flag that records whether it has been sent.

The slow level of the predictor names an existing entry by its queue index and delivers its own verdict. When the two predictions disagree, the stored prediction is replaced and a flush pulse is raised. If the entry had already gone to fetch, sending rewinds to that entry. The entry and every younger one are then sent again.

Execution may resolve an entry's real outcome at any time before commit. Commit removes the oldest entry, sends an update record to the predictor and returns one free-slot credit.

Top module: `fetch_target_queue`

## Requirements
- R1: While reset is asserted, every valid output is low. On the first clock edge after reset, `pcred_valid` pulses with `pcred_count` equal to DEPTH, which is the whole capacity.
- R2: A first-level prediction is written into the entry at the write position. The predictor's running credit total, which is DEPTH plus every returned count minus every enqueue, always equals DEPTH minus the occupancy.
- R3: The block keeps a fetch credit counter. Each `fch_credit` pulse adds one. On each edge where the counter is nonzero and an unsent entry exists, the oldest unsent entry is presented on the `fwd_*` outputs for one cycle, and one credit is consumed.
- R4: A second-level prediction mismatches when its direction differs from the stored one, or when both say taken and the targets differ. A mismatch raises `flush` with `flush_idx` on the next cycle and replaces the stored direction and target.
- R5: A second-level prediction that matches raises no flush and leaves the entry unchanged. A match includes the case where both predictions say not-taken with different targets.
- R6: A mismatch on an entry already sent moves sending back to that entry. That entry, now with its new prediction, and all younger entries are forwarded again. No entry is forwarded on the edge that accepts a mismatch.
- R7: A resolve write stores the corrected direction and target of the named entry. If no resolve arrives, the corrected fields equal the latest prediction held by the entry.
- R8: `commit_valid` removes the oldest entry. On the next cycle, `upd_valid` carries its PC, corrected direction and corrected target. In the same cycle, `pcred_valid` pulses with a count of 1.
- R9: Pointers wrap around the capacity, so entries stay in first-in first-out order across any number of wraps, and DEPTH entries can be held at once.
- R10: Second-level predictions are acted on without any credit check, including when the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p1_valid | input | 1 | First-level prediction present |
| p1_pc | input | AW | Branch PC |
| p1_target | input | AW | Predicted target |
| p1_taken | input | 1 | Predicted direction |
| p2_valid | input | 1 | Second-level prediction present |
| p2_idx | input | IW | Entry it refers to |
| p2_target | input | AW | Second-level target |
| p2_taken | input | 1 | Second-level direction |
| fch_credit | input | 1 | Fetch grants one credit |
| fwd_valid | output | 1 | Entry sent to fetch |
| fwd_idx | output | IW | Index of sent entry |
| fwd_pc | output | AW | PC of sent entry |
| fwd_target | output | AW | Predicted target of sent entry |
| fwd_taken | output | 1 | Predicted direction of sent entry |
| flush | output | 1 | Override mismatch pulse |
| flush_idx | output | IW | Entry that was overridden |
| res_valid | input | 1 | Resolved outcome present |
| res_idx | input | IW | Entry resolved |
| res_target | input | AW | Corrected target |
| res_taken | input | 1 | Corrected direction |
| commit_valid | input | 1 | Retire the oldest entry |
| upd_valid | output | 1 | Update record present |
| upd_pc | output | AW | PC of retired entry |
| upd_target | output | AW | Corrected target |
| upd_taken | output | 1 | Corrected direction |
| pcred_valid | output | 1 | Credit return to predictor |
| pcred_count | output | CW | Number of credits returned |

## Verification
The bench builds the queue with DEPTH of 4, 16-bit addresses and at most 3 outstanding fetch credits. The small depth makes a full queue and pointer wrap occur every few cycles. The random mix therefore often overrides entries in a full queue, overrides entries just before they are sent, and overrides entries that have been sent and are waiting for commit.

The tight fetch credit limit keeps the send point close to the write point. Rewinds therefore regularly re-send entries that then wait for a fresh credit.

// File: rtl/ftq_pkg.sv
package ftq_pkg;
   localparam int unsigned FTQ_DEPTH_DEF = 16;
   localparam int unsigned FTQ_AW_DEF    = 32;
   localparam int unsigned FTQ_FCRED_DEF = 8;

   // verdict of the second-level check on one entry
   typedef enum logic [1:0] {
      P2_IDLE    = 2'd0,
      P2_CONFIRM = 2'd1,
      P2_REPLACE = 2'd2
   } p2_verdict_e;
endpackage

// File: rtl/ftq_store.sv
module ftq_store #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned AW    = 32,
   localparam int unsigned IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enq,
   input  logic [IW-1:0] enq_idx,
   input  logic [AW-1:0] enq_pc,
   input  logic [AW-1:0] enq_tg,
   input  logic          enq_tk,
   input  logic          ovr,
   input  logic [IW-1:0] ovr_idx,
   input  logic [AW-1:0] ovr_tg,
   input  logic          ovr_tk,
   input  logic          res,
   input  logic [IW-1:0] res_idx,
   input  logic [AW-1:0] res_tg,
   input  logic          res_tk,
   input  logic          mark,
   input  logic [IW-1:0] mark_idx,
   input  logic          rew,
   input  logic [IW-1:0] rew_base,
   input  logic [IW-1:0] rew_off,
   input  logic [IW-1:0] a_idx,
   output logic [AW-1:0] a_pc,
   output logic [AW-1:0] a_tg,
   output logic          a_tk,
   input  logic [IW-1:0] b_idx,
   output logic [AW-1:0] b_pc,
   output logic [AW-1:0] b_ctg,
   output logic          b_ctk,
   input  logic [IW-1:0] c_idx,
   output logic [AW-1:0] c_tg,
   output logic          c_tk,
   output logic          c_sent
);
   logic [AW-1:0] pc_q  [DEPTH];
   logic [AW-1:0] ptg_q [DEPTH];
   logic [AW-1:0] ctg_q [DEPTH];
   logic [DEPTH-1:0] ptk_q, ctk_q, sent_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            pc_q[i]  <= '0;
            ptg_q[i] <= '0;
            ctg_q[i] <= '0;
         end
         ptk_q  <= '0;
         ctk_q  <= '0;
         sent_q <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (enq && enq_idx == IW'(i)) begin
               pc_q[i]   <= enq_pc;
               ptg_q[i]  <= enq_tg;
               ptk_q[i]  <= enq_tk;
               ctg_q[i]  <= enq_tg;
               ctk_q[i]  <= enq_tk;
               sent_q[i] <= 1'b0;
            end
            if (ovr && ovr_idx == IW'(i)) begin
               ptg_q[i] <= ovr_tg;
               ptk_q[i] <= ovr_tk;
               ctg_q[i] <= ovr_tg;
               ctk_q[i] <= ovr_tk;
            end
            if (res && res_idx == IW'(i)) begin
               ctg_q[i] <= res_tg;
               ctk_q[i] <= res_tk;
            end
            if (mark && mark_idx == IW'(i))
               sent_q[i] <= 1'b1;
            if (rew && (IW'(i) - rew_base) >= rew_off)
               sent_q[i] <= 1'b0;
         end
      end
   end

   assign a_pc   = pc_q[a_idx];
   assign a_tg   = ptg_q[a_idx];
   assign a_tk   = ptk_q[a_idx];
   assign b_pc   = pc_q[b_idx];
   assign b_ctg  = ctg_q[b_idx];
   assign b_ctk  = ctk_q[b_idx];
   assign c_tg   = ptg_q[c_idx];
   assign c_tk   = ptk_q[c_idx];
   assign c_sent = sent_q[c_idx];

   AST_MARK_REW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mark && rew)); // R6
   AST_ENQ_UNSENT: assert property (@(posedge clk) disable iff (!rst_n)
      enq |=> !sent_q[$past(enq_idx)]); // R3
endmodule

// File: rtl/ftq_fcred.sv
module ftq_fcred #(
   parameter int unsigned MAX = 8,
   localparam int unsigned W  = $clog2(MAX + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic nz
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + W'(inc) - W'(dec);
   end

   assign nz = (cnt_q != '0);

   AST_FCRED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec) |-> (cnt_q < W'(MAX))); // R3
   AST_FCRED_USE: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (cnt_q != '0)); // R3
endmodule

// File: rtl/fetch_target_queue.sv
module fetch_target_queue
   import ftq_pkg::*;
#(
   parameter int unsigned DEPTH     = FTQ_DEPTH_DEF,
   parameter int unsigned AW        = FTQ_AW_DEF,
   parameter int unsigned FCRED_MAX = FTQ_FCRED_DEF,
   localparam int unsigned IW = $clog2(DEPTH),
   localparam int unsigned PW = IW + 1,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          p1_valid,
   input  logic [AW-1:0] p1_pc,
   input  logic [AW-1:0] p1_target,
   input  logic          p1_taken,
   input  logic          p2_valid,
   input  logic [IW-1:0] p2_idx,
   input  logic [AW-1:0] p2_target,
   input  logic          p2_taken,
   input  logic          fch_credit,
   output logic          fwd_valid,
   output logic [IW-1:0] fwd_idx,
   output logic [AW-1:0] fwd_pc,
   output logic [AW-1:0] fwd_target,
   output logic          fwd_taken,
   output logic          flush,
   output logic [IW-1:0] flush_idx,
   input  logic          res_valid,
   input  logic [IW-1:0] res_idx,
   input  logic [AW-1:0] res_target,
   input  logic          res_taken,
   input  logic          commit_valid,
   output logic          upd_valid,
   output logic [AW-1:0] upd_pc,
   output logic [AW-1:0] upd_target,
   output logic          upd_taken,
   output logic          pcred_valid,
   output logic [CW-1:0] pcred_count
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("fetch_target_queue: DEPTH must be a power of two, at least 2");
   end
   if (AW < 2) begin : g_bad_aw
      $error("fetch_target_queue: AW too small");
   end
   if (FCRED_MAX < 1) begin : g_bad_fc
      $error("fetch_target_queue: FCRED_MAX must be at least 1");
   end

   logic [PW-1:0] wr_q, rd_q, snd_q;
   logic [PW-1:0] occ, snd_off;
   logic [IW-1:0] p2_off;
   logic          init_q;
   logic          fc_nz, fwd_go, rew;
   logic [AW-1:0] a_pc, a_tg, b_pc, b_ctg, c_tg;
   logic          a_tk, b_ctk, c_tk, c_sent;
   p2_verdict_e   verdict;

   assign occ     = wr_q - rd_q;
   assign snd_off = snd_q - rd_q;
   assign p2_off  = p2_idx - rd_q[IW-1:0];

   always_comb begin
      verdict = P2_IDLE;
      if (p2_valid) begin
         if ((c_tk != p2_taken) || (p2_taken && (c_tg != p2_target)))
            verdict = P2_REPLACE;
         else
            verdict = P2_CONFIRM;
      end
   end

   assign rew    = (verdict == P2_REPLACE) && c_sent;
   assign fwd_go = (snd_q != wr_q) && fc_nz && (verdict != P2_REPLACE);

   ftq_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .enq      (p1_valid),
      .enq_idx  (wr_q[IW-1:0]),
      .enq_pc   (p1_pc),
      .enq_tg   (p1_target),
      .enq_tk   (p1_taken),
      .ovr      (verdict == P2_REPLACE),
      .ovr_idx  (p2_idx),
      .ovr_tg   (p2_target),
      .ovr_tk   (p2_taken),
      .res      (res_valid),
      .res_idx  (res_idx),
      .res_tg   (res_target),
      .res_tk   (res_taken),
      .mark     (fwd_go),
      .mark_idx (snd_q[IW-1:0]),
      .rew      (rew),
      .rew_base (rd_q[IW-1:0]),
      .rew_off  (p2_off),
      .a_idx    (snd_q[IW-1:0]),
      .a_pc     (a_pc),
      .a_tg     (a_tg),
      .a_tk     (a_tk),
      .b_idx    (rd_q[IW-1:0]),
      .b_pc     (b_pc),
      .b_ctg    (b_ctg),
      .b_ctk    (b_ctk),
      .c_idx    (p2_idx),
      .c_tg     (c_tg),
      .c_tk     (c_tk),
      .c_sent   (c_sent)
   );

   ftq_fcred #(.MAX(FCRED_MAX)) u_fcred (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (fch_credit),
      .dec   (fwd_go),
      .nz    (fc_nz)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q        <= '0;
         rd_q        <= '0;
         snd_q       <= '0;
         init_q      <= 1'b1;
         fwd_valid   <= 1'b0;
         fwd_idx     <= '0;
         fwd_pc      <= '0;
         fwd_target  <= '0;
         fwd_taken   <= 1'b0;
         flush       <= 1'b0;
         flush_idx   <= '0;
         upd_valid   <= 1'b0;
         upd_pc      <= '0;
         upd_target  <= '0;
         upd_taken   <= 1'b0;
         pcred_valid <= 1'b0;
         pcred_count <= '0;
      end else begin
         if (p1_valid)     wr_q <= wr_q + PW'(1);
         if (commit_valid) rd_q <= rd_q + PW'(1);
         if (rew)          snd_q <= rd_q + PW'(p2_off);
         else if (fwd_go)  snd_q <= snd_q + PW'(1);

         fwd_valid <= fwd_go;
         if (fwd_go) begin
            fwd_idx    <= snd_q[IW-1:0];
            fwd_pc     <= a_pc;
            fwd_target <= a_tg;
            fwd_taken  <= a_tk;
         end

         flush <= (verdict == P2_REPLACE);
         if (verdict == P2_REPLACE) flush_idx <= p2_idx;

         upd_valid <= commit_valid;
         if (commit_valid) begin
            upd_pc     <= b_pc;
            upd_target <= b_ctg;
            upd_taken  <= b_ctk;
         end

         init_q      <= 1'b0;
         pcred_valid <= init_q | commit_valid;
         pcred_count <= init_q ? CW'(DEPTH) : CW'(1);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      p1_valid |-> (occ < PW'(DEPTH))); // R2
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid |-> (occ != '0)); // R8
   AST_SEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      snd_off <= occ); // R6
   AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> $past(p2_valid)); // R4
   AST_NO_FWD_ON_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !fwd_valid); // R6
   AST_UPD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> ($past(commit_valid) && pcred_valid)); // R8
endmodule

// File: tb/tb_fetch_target_queue.sv
module tb_fetch_target_queue;
   localparam int D  = 4;
   localparam int AW = 16;
   localparam int IW = 2;
   localparam int FC = 3;
   localparam int CW = $clog2(D + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          p1_valid = 0, p1_taken = 0, p2_valid = 0, p2_taken = 0;
   logic [AW-1:0] p1_pc = 0, p1_target = 0, p2_target = 0, res_target = 0;
   logic [IW-1:0] p2_idx = 0, res_idx = 0;
   logic          fch_credit = 0, res_valid = 0, res_taken = 0, commit_valid = 0;
   logic          fwd_valid, fwd_taken, flush, upd_valid, upd_taken, pcred_valid;
   logic [IW-1:0] fwd_idx, flush_idx;
   logic [AW-1:0] fwd_pc, fwd_target, upd_pc, upd_target;
   logic [CW-1:0] pcred_count;

   fetch_target_queue #(.DEPTH(D), .AW(AW), .FCRED_MAX(FC)) dut (
      .clk(clk), .rst_n(rst_n),
      .p1_valid(p1_valid), .p1_pc(p1_pc), .p1_target(p1_target), .p1_taken(p1_taken),
      .p2_valid(p2_valid), .p2_idx(p2_idx), .p2_target(p2_target), .p2_taken(p2_taken),
      .fch_credit(fch_credit),
      .fwd_valid(fwd_valid), .fwd_idx(fwd_idx), .fwd_pc(fwd_pc),
      .fwd_target(fwd_target), .fwd_taken(fwd_taken),
      .flush(flush), .flush_idx(flush_idx),
      .res_valid(res_valid), .res_idx(res_idx), .res_target(res_target), .res_taken(res_taken),
      .commit_valid(commit_valid),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target), .upd_taken(upd_taken),
      .pcred_valid(pcred_valid), .pcred_count(pcred_count)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model
   logic [AW-1:0] m_pc [D];
   logic [AW-1:0] m_tg [D];
   logic [AW-1:0] m_ctg[D];
   logic          m_tk [D];
   logic          m_ctk[D];
   int m_rd = 0, m_wr = 0, m_snd = 0, m_fc = 0, m_pcr = 0;
   bit m_init = 1;

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   function automatic int occ();
      return m_wr - m_rd;
   endfunction

   function automatic bit mism(input int i, input bit tk, input logic [AW-1:0] tg);
      return (m_tk[i] != tk) || (tk && m_tg[i] != tg);
   endfunction

   // one cycle: called at a negedge, returns at the following negedge
   task automatic step(input bit a1, input logic [AW-1:0] pc, input logic [AW-1:0] tg, input bit tk,
                       input bit a2, input int i2, input logic [AW-1:0] tg2, input bit tk2,
                       input bit ar, input int ri, input logic [AW-1:0] rtg, input bit rtk,
                       input bit ac, input bit agf);
      bit e_fv, e_fl, e_uv, e_cv, mm, snt;
      int e_fi, e_cc, off, si, ci;
      logic [AW-1:0] e_fpc, e_ftg, e_upc, e_utg;
      logic e_ftk, e_utk;
      p1_valid = a1; p1_pc = pc; p1_target = tg; p1_taken = tk;
      p2_valid = a2; p2_idx = IW'(i2); p2_target = tg2; p2_taken = tk2;
      res_valid = ar; res_idx = IW'(ri); res_target = rtg; res_taken = rtk;
      commit_valid = ac; fch_credit = agf;
      mm  = a2 && mism(i2, tk2, tg2);
      off = (i2 - m_rd) & (D - 1);
      snt = off < (m_snd - m_rd);
      e_fl = mm;
      e_fv = !mm && (m_snd != m_wr) && (m_fc > 0);
      si = m_snd % D;
      e_fi = si; e_fpc = m_pc[si]; e_ftg = m_tg[si]; e_ftk = m_tk[si];
      ci = m_rd % D;
      e_uv = ac; e_upc = m_pc[ci]; e_utg = m_ctg[ci]; e_utk = m_ctk[ci];
      e_cv = m_init || ac; e_cc = m_init ? D : 1;
      m_init = 0;
      if (e_fv) begin m_snd++; m_fc--; end
      if (agf) m_fc++;
      if (a1) begin
         m_pc[m_wr % D] = pc; m_tg[m_wr % D] = tg; m_tk[m_wr % D] = tk;
         m_ctg[m_wr % D] = tg; m_ctk[m_wr % D] = tk; m_wr++;
         m_pcr--;
      end
      if (mm) begin
         m_tg[i2] = tg2; m_tk[i2] = tk2; m_ctg[i2] = tg2; m_ctk[i2] = tk2;
         if (snt) m_snd = m_rd + off;
      end
      if (ar) begin m_ctg[ri] = rtg; m_ctk[ri] = rtk; end
      if (ac) m_rd++;
      @(posedge clk);
      @(negedge clk);
      chk(fwd_valid == e_fv, "R3", "fwd_valid", fwd_valid, e_fv);
      if (e_fv) begin
         chk(fwd_idx == IW'(e_fi), "R9", "fwd_idx", fwd_idx, e_fi);
         chk(fwd_pc == e_fpc, "R9", "fwd_pc", fwd_pc, e_fpc);
         chk(fwd_target == e_ftg, "R6", "fwd_target", fwd_target, e_ftg);
         chk(fwd_taken == e_ftk, "R6", "fwd_taken", fwd_taken, e_ftk);
      end
      chk(flush == e_fl, e_fl ? "R4" : "R5", "flush", flush, e_fl);
      if (e_fl) chk(flush_idx == IW'(i2), "R4", "flush_idx", flush_idx, i2);
      chk(upd_valid == e_uv, "R8", "upd_valid", upd_valid, e_uv);
      if (e_uv) begin
         chk(upd_pc == e_upc, "R8", "upd_pc", upd_pc, e_upc);
         chk(upd_target == e_utg, "R7", "upd_target", upd_target, e_utg);
         chk(upd_taken == e_utk, "R7", "upd_taken", upd_taken, e_utk);
      end
      chk(pcred_valid == e_cv, "R8", "pcred_valid", pcred_valid, e_cv);
      if (e_cv) chk(pcred_count == CW'(e_cc), "R8", "pcred_count", pcred_count, e_cc);
      if (pcred_valid) m_pcr += int'(pcred_count);
      chk(m_pcr == D - occ(), "R2", "credit total", m_pcr, D - occ());
      p1_valid = 0; p2_valid = 0; res_valid = 0; commit_valid = 0; fch_credit = 0;
   endtask

   task automatic idle(input bit agf);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, agf);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R3 watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < D; i++) begin
         m_pc[i] = 0; m_tg[i] = 0; m_ctg[i] = 0; m_tk[i] = 0; m_ctk[i] = 0;
      end
      repeat (3) @(negedge clk);
      // R1: quiet outputs during reset
      chk(!fwd_valid && !flush && !upd_valid && !pcred_valid, "R1", "outputs in reset",
          {fwd_valid, flush, upd_valid, pcred_valid}, 0);
      rst_n = 1;
      idle(0);
      chk(m_pcr == D, "R1", "initial credits", m_pcr, D);

      // fill to capacity without fetch credits (R9, R2)
      for (int k = 0; k < D; k++)
         step(1, AW'(16'h100 + k * 4), AW'(16'h800 + k), k[0], 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      // R10: override in a full queue
      step(0, 0, 0, 0, 1, 2, AW'(16'h5555), !m_tk[2], 0, 0, 0, 0, 0, 0);
      chk(flush == 1'b1, "R10", "flush when full", flush, 1);
      // R5: matching not-taken with a different target
      if (!m_tk[3]) step(0, 0, 0, 0, 1, 3, ~m_tg[3], 1'b0, 0, 0, 0, 0, 0, 0);
      else          step(0, 0, 0, 0, 1, 3, m_tg[3], 1'b1, 0, 0, 0, 0, 0, 0);
      chk(flush == 1'b0, "R5", "no flush on match", flush, 0);
      // forward entries 0..2
      idle(1); idle(1); idle(1); idle(0);
      // R6: override a sent entry, expect it forwarded again
      step(0, 0, 0, 0, 1, 1, AW'(16'h7777), !m_tk[1], 0, 0, 0, 0, 0, 0);
      idle(1);
      idle(0);
      chk(fwd_valid && fwd_idx == 2'd1, "R6", "re-forward index", fwd_idx, 1);
      chk(fwd_target == AW'(16'h7777) || !m_tk[1], "R6", "re-forward target", fwd_target, 16'h7777);

      // constrained random phase
      for (int n = 0; n < 4000; n++) begin
         bit a1, a2, ar, ac, gf, tk, tk2;
         int op, i2;
         logic [AW-1:0] tg2;
         op = $urandom % 4;
         a1 = (occ() < D) && ($urandom % 2 == 0);
         gf = (m_fc < FC) && ($urandom % 3 != 0);
         ac = (op == 0) && (m_snd > m_rd);
         a2 = (op == 1) && (occ() > 0);
         ar = (op == 2) && (occ() > 0);
         i2 = (occ() > 0) ? (m_rd + int'($urandom % occ())) % D : 0;
         tk = $urandom % 2;
         if ($urandom % 2 == 0) begin
            tk2 = m_tk[i2];
            tg2 = tk2 ? m_tg[i2] : AW'($urandom);
         end else begin
            tk2 = $urandom % 2;
            tg2 = ($urandom % 2 == 0) ? m_tg[i2] : AW'($urandom);
         end
         step(a1, AW'($urandom), AW'($urandom), tk, a2, i2, tg2, tk2,
              ar, i2, AW'($urandom), $urandom % 2, ac, gf);
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule